// File: doc/BRIEF.md
# Linked-Descriptor Byte Streaming DMA

This block moves bytes to a peripheral transmit port under the control of a chain of descriptors. Each descriptor lives in a descriptor memory that the CPU shares with the block. Software writes the word address of the first descriptor into a start register. The engine reads the four descriptor words and then streams the requested bytes onto a valid/ready byte output. The bytes come either from a data memory, walked with a programmable stride, or from an external data-port FIFO. When a descriptor is done, the engine follows its next pointer or stops, as its control bits say.

Control bits in each descriptor select four things: a one-cycle interrupt pulse when the descriptor completes, chaining to the next descriptor, and a flush request to the downstream packet FIFO. The flush request is held until the packet FIFO accepts it, so a packet built from several descriptors leaves in one piece. The fourth bit selects the data-port source. In that mode the upstream side may cancel the transfer early. A cancel stops the engine at once. Software then reads the current byte count to find out how much of the descriptor went out, and pads the packet if it needs to.

Top module: `dma_chain_streamer`

## Requirements
- R1: A write of a descriptor word address to register 0 while the engine is idle starts the engine. Its first descriptor-memory read is at that address, and the following reads are at the next three word addresses. A write to register 0 while the engine is busy is ignored.
- R2: A descriptor is four words: word 0 is the next pointer, word 1 the data pointer, word 2 the increment, and word 3 the descriptor's control. Word 3 holds the count in bits 15:0, IRQ in bit 16, EN in bit 17, FL in bit 18 and DP in bit 19. Each descriptor transfers count+1 bytes.
- R3: With DP clear, byte i of a descriptor is read from data address ptr + i*inc, taken modulo 2^DATA_AW (the address wraps).
- R4: With DP set, the bytes are the data-port FIFO entries in FIFO order, and the pointer and increment fields are ignored. dp_ready is asserted only while dp_valid is high.
- R5: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R6: The cycle after a descriptor completes, irq pulses high for one cycle if that descriptor's IRQ bit is 1. It stays low if the bit is 0.
- R7: When a descriptor completes with EN=1, the engine fetches the descriptor at its next pointer. With EN=0 the engine becomes idle and sends no further bytes.
- R8: With FL=1, flush_req rises only after the descriptor's last byte has been accepted. It stays high until flush_ack is seen, and no byte is offered while it is high.
- R9: dp_cancel while a DP descriptor is streaming makes the engine idle at the next edge, regardless of EN. It sends no further bytes and raises no interrupt. dp_cancel has no effect during a descriptor with DP clear.
- R10: Register 1 bit 0 reads the busy flag, which is 1 from the start write until the engine stops. Register 2 reads the number of bytes accepted for the current descriptor. That count is cleared when each descriptor's fetch completes.
- R11: After reset the engine is idle, with busy, the count register, out_valid, flush_req and irq all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 start, 1 status, 2 count |
| reg_wdata | input | 32 | Register write data (start descriptor address) |
| reg_rdata | output | 32 | Register read data for reg_addr |
| desc_rd_en | output | 1 | Descriptor memory read enable |
| desc_rd_addr | output | DESC_AW | Descriptor memory word address |
| desc_rd_data | input | 32 | Descriptor memory read data, one cycle after enable |
| dat_rd_en | output | 1 | Data memory read enable |
| dat_rd_addr | output | DATA_AW | Data memory byte address |
| dat_rd_data | input | 8 | Data memory read data, one cycle after enable |
| dp_valid | input | 1 | Data-port FIFO has a byte |
| dp_data | input | 8 | Data-port FIFO head byte |
| dp_ready | output | 1 | Pop the data-port FIFO head |
| dp_cancel | input | 1 | Data-port stream ended early |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Peripheral accepts the output byte |
| flush_req | output | 1 | Ask the packet FIFO to send the assembled packet |
| flush_ack | input | 1 | Packet FIFO accepted the flush |
| irq | output | 1 | Descriptor-complete interrupt pulse |

## Verification
The bench targets the following cases, each paired with the failure it would expose:
- A stride walk whose data pointer wraps past the top of the address space. A design with the wrong address width or a missing wrap would send bytes from the wrong addresses.
- A three-descriptor chain that mixes memory and data-port sources with two flushes. A design that flushed early, or skipped the wait for flush_ack, would be caught by the byte total at the flush.
- A mid-stream cancel on a chained data-port descriptor. A design that honoured EN after the cancel would fetch onward or raise irq, and one that kept counting would report the wrong residual count.
- A start write while busy, and a cancel during a memory-sourced descriptor. A design that obeyed either one would change the byte sequence.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    localparam int WORD_W     = 32;
    localparam int CNT_W      = 16;
    localparam int CTL_LSB    = 16;
    localparam int DESC_WORDS = 4;
    localparam int BYTE_W     = 8;

    localparam logic [1:0] RA_START  = 2'd0;
    localparam logic [1:0] RA_STATUS = 2'd1;
    localparam logic [1:0] RA_COUNT  = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_MOVE,
        ST_FLUSH
    } dcs_state_e;

    // bit 0 irq, bit 1 chain, bit 2 flush, bit 3 data-port source
    typedef struct packed {
        logic dp;
        logic fl;
        logic en;
        logic irq;
    } dcs_ctl_t;

    typedef struct packed {
        logic [WORD_W-1:0] next_ptr;
        logic [WORD_W-1:0] data_ptr;
        logic [WORD_W-1:0] step;
        logic [CNT_W-1:0]  count;
        dcs_ctl_t          ctl;
    } dcs_desc_t;

    function automatic dcs_desc_t dcs_unpack(input logic [WORD_W-1:0] w0,
                                             input logic [WORD_W-1:0] w1,
                                             input logic [WORD_W-1:0] w2,
                                             input logic [WORD_W-1:0] w3);
        dcs_desc_t d;
        d.next_ptr = w0;
        d.data_ptr = w1;
        d.step     = w2;
        d.count    = w3[CNT_W-1:0];
        d.ctl      = dcs_ctl_t'(w3[CTL_LSB +: 4]);
        return d;
    endfunction

endpackage

// File: rtl/dcs_desc_fetch.sv
module dcs_desc_fetch
    import dcs_pkg::*;
#(
    parameter int DESC_AW = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               go,
    input  logic [DESC_AW-1:0] base,
    output logic               rd_en,
    output logic [DESC_AW-1:0] rd_addr,
    input  logic [WORD_W-1:0]  rd_data,
    output logic               done,
    output dcs_desc_t          desc
);
    localparam int STEP_W = $clog2(DESC_WORDS + 2);
    localparam int IDX_W  = $clog2(DESC_WORDS);
    localparam logic [STEP_W-1:0] NUM_WORDS = STEP_W'(DESC_WORDS);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(DESC_WORDS + 1);

    logic                active_q;
    logic [STEP_W-1:0]   step_q;
    logic [DESC_AW-1:0]  base_q;
    logic [WORD_W-1:0]   word_q [DESC_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            step_q   <= '0;
            base_q   <= '0;
        end else if (go) begin
            active_q <= 1'b1;
            step_q   <= '0;
            base_q   <= base;
        end else if (active_q) begin
            step_q <= step_q + 1'b1;
            if (step_q == LAST_STEP) active_q <= 1'b0;
        end
    end

    // read data returns one cycle after its address
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DESC_WORDS; i++) word_q[i] <= '0;
        end else if (active_q && step_q != '0 && step_q <= NUM_WORDS) begin
            word_q[IDX_W'(step_q - 1'b1)] <= rd_data;
        end
    end

    assign rd_en   = active_q && (step_q < NUM_WORDS);
    assign rd_addr = base_q + DESC_AW'(step_q);
    assign done    = active_q && (step_q == LAST_STEP);
    assign desc    = dcs_unpack(word_q[0], word_q[1], word_q[2], word_q[3]);

endmodule

// File: rtl/dcs_byte_src.sv
module dcs_byte_src
    import dcs_pkg::*;
#(
    parameter int DATA_AW = 16,
    parameter int CUR_W   = 17
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               kill,
    input  logic               run,
    input  logic [DATA_AW-1:0] ptr_in,
    input  logic [DATA_AW-1:0] step_in,
    input  logic [CUR_W-1:0]   total_in,
    input  logic               dp_in,
    output logic               dat_rd_en,
    output logic [DATA_AW-1:0] dat_rd_addr,
    input  logic [BYTE_W-1:0]  dat_rd_data,
    input  logic               dp_valid,
    input  logic [BYTE_W-1:0]  dp_data,
    output logic               dp_ready,
    output logic               out_valid,
    output logic [BYTE_W-1:0]  out_data,
    input  logic               out_ready,
    output logic               acc,
    output logic               last
);
    logic [DATA_AW-1:0] ptr_q;
    logic [DATA_AW-1:0] step_q;
    logic [CUR_W-1:0]   rem_q;
    logic               dp_q;
    logic               pend_q;
    logic               obuf_v;
    logic [BYTE_W-1:0]  obuf_d;
    logic               slot_free;

    assign slot_free   = run && (rem_q != '0) && !obuf_v && !pend_q;
    assign dat_rd_en   = slot_free && !dp_q;
    assign dat_rd_addr = ptr_q;
    assign dp_ready    = slot_free && dp_q && dp_valid;
    assign out_valid   = obuf_v;
    assign out_data    = obuf_d;
    assign acc         = run && obuf_v && out_ready;
    assign last        = acc && (rem_q == '0) && !pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            step_q <= '0;
            rem_q  <= '0;
            dp_q   <= 1'b0;
            pend_q <= 1'b0;
            obuf_v <= 1'b0;
            obuf_d <= '0;
        end else if (kill) begin
            rem_q  <= '0;
            pend_q <= 1'b0;
            obuf_v <= 1'b0;
        end else if (load) begin
            ptr_q  <= ptr_in;
            step_q <= step_in;
            rem_q  <= total_in;
            dp_q   <= dp_in;
            pend_q <= 1'b0;
            obuf_v <= 1'b0;
        end else begin
            pend_q <= dat_rd_en;
            if (dat_rd_en) begin
                ptr_q <= ptr_q + step_q;
                rem_q <= rem_q - 1'b1;
            end else if (dp_ready) begin
                rem_q <= rem_q - 1'b1;
            end
            if (pend_q) begin
                obuf_v <= 1'b1;
                obuf_d <= dat_rd_data;
            end else if (dp_ready) begin
                obuf_v <= 1'b1;
                obuf_d <= dp_data;
            end else if (acc) begin
                obuf_v <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dma_chain_streamer.sv
module dma_chain_streamer
    import dcs_pkg::*;
#(
    parameter int DESC_AW = 8,
    parameter int DATA_AW = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr_en,
    input  logic [1:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               desc_rd_en,
    output logic [DESC_AW-1:0] desc_rd_addr,
    input  logic [31:0]        desc_rd_data,
    output logic               dat_rd_en,
    output logic [DATA_AW-1:0] dat_rd_addr,
    input  logic [7:0]         dat_rd_data,
    input  logic               dp_valid,
    input  logic [7:0]         dp_data,
    output logic               dp_ready,
    input  logic               dp_cancel,
    output logic               out_valid,
    output logic [7:0]         out_data,
    input  logic               out_ready,
    output logic               flush_req,
    input  logic               flush_ack,
    output logic               irq
);
    localparam int CUR_W = CNT_W + 1;

    dcs_state_e         state_q;
    dcs_desc_t          cur_q;
    dcs_desc_t          fetched;
    logic [CUR_W-1:0]   cur_cnt_q;
    logic               irq_q;
    logic               busy;
    logic               fetch_go;
    logic               fetch_done;
    logic [DESC_AW-1:0] fetch_base;
    logic               start_hit;
    logic               cancel_hit;
    logic               desc_end;
    logic               chain_go;
    logic               acc;
    logic               last;

    assign busy       = (state_q != ST_IDLE);
    assign start_hit  = reg_wr_en && (reg_addr == RA_START) && !busy;
    assign cancel_hit = (state_q == ST_MOVE) && cur_q.ctl.dp && dp_cancel;
    assign desc_end   = !cancel_hit &&
                        (((state_q == ST_MOVE) && last && !cur_q.ctl.fl) ||
                         ((state_q == ST_FLUSH) && flush_ack));
    assign chain_go   = desc_end && cur_q.ctl.en;
    assign fetch_go   = start_hit || chain_go;
    assign fetch_base = start_hit ? reg_wdata[DESC_AW-1:0] : cur_q.next_ptr[DESC_AW-1:0];
    assign flush_req  = (state_q == ST_FLUSH);
    assign irq        = irq_q;

    dcs_desc_fetch #(.DESC_AW(DESC_AW)) u_fetch (
        .clk     (clk),
        .rst     (rst),
        .go      (fetch_go),
        .base    (fetch_base),
        .rd_en   (desc_rd_en),
        .rd_addr (desc_rd_addr),
        .rd_data (desc_rd_data),
        .done    (fetch_done),
        .desc    (fetched)
    );

    dcs_byte_src #(.DATA_AW(DATA_AW), .CUR_W(CUR_W)) u_src (
        .clk         (clk),
        .rst         (rst),
        .load        (fetch_done),
        .kill        (cancel_hit),
        .run         (state_q == ST_MOVE),
        .ptr_in      (fetched.data_ptr[DATA_AW-1:0]),
        .step_in     (fetched.step[DATA_AW-1:0]),
        .total_in    (CUR_W'(fetched.count) + 1'b1),
        .dp_in       (fetched.ctl.dp),
        .dat_rd_en   (dat_rd_en),
        .dat_rd_addr (dat_rd_addr),
        .dat_rd_data (dat_rd_data),
        .dp_valid    (dp_valid),
        .dp_data     (dp_data),
        .dp_ready    (dp_ready),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_ready   (out_ready),
        .acc         (acc),
        .last        (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cur_q     <= '0;
            cur_cnt_q <= '0;
            irq_q     <= 1'b0;
        end else begin
            irq_q <= desc_end && cur_q.ctl.irq;
            if (fetch_done)  cur_cnt_q <= '0;
            else if (acc)    cur_cnt_q <= cur_cnt_q + 1'b1;
            unique case (state_q)
                ST_IDLE:  if (start_hit) state_q <= ST_FETCH;
                ST_FETCH: if (fetch_done) begin
                    cur_q   <= fetched;
                    state_q <= ST_MOVE;
                end
                ST_MOVE: begin
                    if (cancel_hit)            state_q <= ST_IDLE;
                    else if (last && cur_q.ctl.fl) state_q <= ST_FLUSH;
                    else if (desc_end)         state_q <= chain_go ? ST_FETCH : ST_IDLE;
                end
                ST_FLUSH: if (desc_end) state_q <= chain_go ? ST_FETCH : ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (reg_addr)
            RA_STATUS: reg_rdata = {31'd0, busy};
            RA_COUNT:  reg_rdata = {{(32 - CUR_W){1'b0}}, cur_cnt_q};
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dcs_checker.sv
module dcs_checker (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       irq,
    input logic       flush_req,
    input logic       flush_ack,
    input logic       dp_valid,
    input logic       dp_ready,
    input logic       desc_rd_en,
    input logic       dat_rd_en
);
    // R5
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R6
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R8
    flush_hold_chk: assert property (@(posedge clk) disable iff (rst)
        flush_req && !flush_ack |=> flush_req);

    // R8
    flush_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> !out_valid);

    // R4
    dp_pop_chk: assert property (@(posedge clk) disable iff (rst)
        dp_ready |-> dp_valid);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !out_valid && !desc_rd_en && !dat_rd_en && !flush_req);

    // R1
    one_port_chk: assert property (@(posedge clk) disable iff (rst)
        !(desc_rd_en && dat_rd_en));

endmodule

bind dma_chain_streamer dcs_checker u_dcs_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .irq        (irq),
    .flush_req  (flush_req),
    .flush_ack  (flush_ack),
    .dp_valid   (dp_valid),
    .dp_ready   (dp_ready),
    .desc_rd_en (desc_rd_en),
    .dat_rd_en  (dat_rd_en)
);

// File: tb/dma_chain_streamer_bench.sv
module dma_chain_streamer_bench;
    localparam int DESC_AW = 8;
    localparam int DATA_AW = 16;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               reg_wr_en = 1'b0;
    logic [1:0]         reg_addr = 2'd0;
    logic [31:0]        reg_wdata = 32'd0;
    logic [31:0]        reg_rdata;
    logic               desc_rd_en;
    logic [DESC_AW-1:0] desc_rd_addr;
    logic [31:0]        desc_rd_data = 32'd0;
    logic               dat_rd_en;
    logic [DATA_AW-1:0] dat_rd_addr;
    logic [7:0]         dat_rd_data = 8'd0;
    logic               dp_valid = 1'b0;
    logic [7:0]         dp_data = 8'd0;
    logic               dp_ready;
    logic               dp_cancel = 1'b0;
    logic               out_valid;
    logic [7:0]         out_data;
    logic               out_ready = 1'b0;
    logic               flush_req;
    logic               flush_ack = 1'b0;
    logic               irq;

    always #2.5 clk = ~clk;

    dma_chain_streamer #(.DESC_AW(DESC_AW), .DATA_AW(DATA_AW)) u_dma_chain_streamer (.*);

    int checks = 0;
    int errors = 0;
    logic [31:0] desc_mem [64];
    logic [7:0]  exp_b [$];
    string       exp_r [$];
    int          exp_irq [$];
    int          exp_fl [$];
    logic [7:0]  dp_src [$];
    int          total_out = 0;
    int          planned = 0;
    int          dp_seed = 1;
    logic [7:0]  lfsr = 8'h5B;
    bit          dp_pop = 0;
    bit          stall_prev = 0;
    logic [7:0]  stall_d = 8'd0;
    bit          fl_prev = 0;
    int          fl_wait = 0;
    bit          fetch_watch = 0;
    int          fetch_expect = 0;

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // R2 layout: word3 = count[15:0], IRQ 16, EN 17, FL 18, DP 19
    task automatic put_desc(input int a, input int nxt, input int ptr, input int inc,
                            input int cnt, input bit f_irq, input bit f_en,
                            input bit f_fl, input bit f_dp);
        desc_mem[a]   = nxt;
        desc_mem[a+1] = ptr;
        desc_mem[a+2] = inc;
        desc_mem[a+3] = {12'd0, f_dp, f_fl, f_en, f_irq, 16'(cnt)};
    endtask

    // behavioural walk of a descriptor chain
    task automatic plan_chain(input int start);
        int a = start;
        planned = total_out;
        forever begin
            logic [31:0] w3 = desc_mem[a+3];
            int n = int'(w3[15:0]) + 1;
            for (int i = 0; i < n; i++) begin
                if (w3[19]) begin
                    logic [7:0] b = 8'(dp_seed * 37 + 11);
                    dp_seed++;
                    dp_src.push_back(b);
                    exp_b.push_back(b);
                    exp_r.push_back("R4");
                end else begin
                    logic [15:0] ad = 16'(desc_mem[a+1] + i * desc_mem[a+2]);
                    exp_b.push_back(mem_byte(ad));
                    exp_r.push_back("R3");
                end
            end
            planned += n;
            if (w3[18]) exp_fl.push_back(planned);
            if (w3[16]) exp_irq.push_back(planned);
            if (!w3[17]) break;
            a = int'(desc_mem[a][5:0]);
        end
    endtask

    always @(posedge clk) begin
        if (desc_rd_en) desc_rd_data <= desc_mem[desc_rd_addr[5:0]];
        if (dat_rd_en)  dat_rd_data  <= mem_byte(dat_rd_addr);
    end

    // per-cycle driver and comparator
    always begin
        @(posedge clk);
        #1;
        if (dp_pop) begin
            void'(dp_src.pop_front());
            dp_pop = 0;
        end
        lfsr      = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready = lfsr[0] | lfsr[4];
        dp_valid  = (dp_src.size() > 0) && lfsr[2];
        dp_data   = (dp_src.size() > 0) ? dp_src[0] : 8'd0;
        flush_ack = flush_req && (fl_wait >= 3);
        fl_wait   = flush_req ? fl_wait + 1 : 0;
        #3;
        if (!rst) begin
            if (stall_prev)
                check(out_valid && out_data == stall_d, "R5", "held byte",
                      {out_valid, out_data}, {1'b1, stall_d});
            stall_prev = out_valid && !out_ready;
            stall_d    = out_data;
            if (out_valid && out_ready) begin
                if (exp_b.size() == 0) begin
                    check(0, "R7", "unexpected byte", out_data, 0);
                end else begin
                    check(out_data == exp_b[0], exp_r[0], "byte", out_data, exp_b[0]);
                    void'(exp_b.pop_front());
                    void'(exp_r.pop_front());
                end
                total_out++;
            end
            if (dp_valid && dp_ready) dp_pop = 1;
            if (irq) begin
                if (exp_irq.size() == 0) begin
                    check(0, "R6", "unexpected irq at byte total", total_out, -1);
                end else begin
                    check(exp_irq[0] == total_out, "R6", "irq position", total_out, exp_irq[0]);
                    void'(exp_irq.pop_front());
                end
            end
            if (flush_req && !fl_prev) begin
                if (exp_fl.size() == 0) begin
                    check(0, "R8", "unexpected flush at byte total", total_out, -1);
                end else begin
                    check(exp_fl[0] == total_out, "R8", "flush position", total_out, exp_fl[0]);
                    void'(exp_fl.pop_front());
                end
            end
            fl_prev = flush_req;
            if (desc_rd_en && fetch_watch) begin
                check(int'(desc_rd_addr) == fetch_expect, "R1", "first fetch address",
                      desc_rd_addr, fetch_expect);
                fetch_watch = 0;
            end
        end
    end

    task automatic read_reg(input logic [1:0] a, output logic [31:0] v);
        @(posedge clk);
        #1 reg_addr = a;
        #2 v = reg_rdata;
    endtask

    task automatic write_start(input int a, input bit watch);
        @(posedge clk);
        #1;
        reg_wr_en = 1'b1;
        reg_addr  = 2'd0;
        reg_wdata = a;
        if (watch) begin
            fetch_watch  = 1;
            fetch_expect = a;
        end
        @(posedge clk);
        #1 reg_wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 5000; i++) begin
            read_reg(2'd1, v);
            if (v[0] == 1'b0) break;
        end
        repeat (3) @(posedge clk);
    endtask

    task automatic pulse_cancel();
        @(posedge clk);
        #1 dp_cancel = 1'b1;
        @(posedge clk);
        #1 dp_cancel = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        check(0, "R7", "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int base;
        for (int i = 0; i < 64; i++) desc_mem[i] = 32'd0;
        put_desc(0,  40, 32'h0010, 1, 3, 1, 0, 0, 0);
        put_desc(8,  16, 32'h0100, 3, 1, 0, 1, 1, 0);
        put_desc(16, 24, 32'hDEAD, 7, 2, 1, 1, 0, 1);
        put_desc(24, 0,  32'hFFFE, 1, 2, 1, 0, 1, 0);
        put_desc(32, 0,  32'h0000, 1, 9, 1, 1, 0, 1);

        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R11 reset state
        read_reg(2'd1, v);
        check(v[0] == 1'b0, "R11", "busy after reset", v, 0);
        check(!out_valid && !flush_req && !irq, "R11", "outputs after reset",
              {out_valid, flush_req, irq}, 0);
        read_reg(2'd2, v);
        check(v == 0, "R11", "count after reset", v, 0);

        // single memory descriptor; cancel must be ignored (R9)
        plan_chain(0);
        write_start(0, 1);
        read_reg(2'd1, v);
        check(v[0] == 1'b1, "R10", "busy after start", v, 1);
        repeat (8) @(posedge clk);
        pulse_cancel();
        wait_idle();
        check(exp_b.size() == 0, "R9", "bytes left after ignored cancel", exp_b.size(), 0);
        check(exp_irq.size() == 0, "R6", "irq missing", exp_irq.size(), 0);
        read_reg(2'd2, v);
        check(v == 4, "R10", "count after single descriptor", v, 4);

        // chain: memory+flush, data port+irq, wrapping memory+flush+irq
        plan_chain(8);
        write_start(8, 1);
        repeat (10) @(posedge clk);
        write_start(0, 0);
        wait_idle();
        check(exp_b.size() == 0, "R7", "chain bytes left", exp_b.size(), 0);
        check(exp_fl.size() == 0, "R8", "flush missing", exp_fl.size(), 0);
        check(exp_irq.size() == 0, "R6", "chain irq missing", exp_irq.size(), 0);
        check(dp_src.size() == 0, "R4", "fifo bytes left", dp_src.size(), 0);
        read_reg(2'd2, v);
        check(v == 3, "R2", "count of last chained descriptor", v, 3);

        // data-port descriptor cancelled after three bytes
        base = total_out;
        for (int i = 0; i < 3; i++) begin
            logic [7:0] b = 8'(8'hC0 + i);
            dp_src.push_back(b);
            exp_b.push_back(b);
            exp_r.push_back("R4");
        end
        write_start(32, 1);
        for (int i = 0; i < 2000; i++) begin
            @(posedge clk);
            #1;
            if (total_out == base + 3) break;
        end
        dp_cancel = 1'b1;
        @(posedge clk);
        #1 dp_cancel = 1'b0;
        read_reg(2'd1, v);
        check(v[0] == 1'b0, "R9", "busy after cancel", v, 0);
        repeat (20) @(posedge clk);
        check(total_out == base + 3, "R9", "bytes after cancel", total_out - base, 3);
        read_reg(2'd2, v);
        check(v == 3, "R10", "count after cancel", v, 3);
        read_reg(2'd1, v);
        check(v[0] == 1'b0, "R9", "still idle after cancel", v, 0);

        // restart after cancel
        plan_chain(0);
        write_start(0, 1);
        wait_idle();
        check(exp_b.size() == 0, "R1", "restart bytes left", exp_b.size(), 0);
        read_reg(2'd2, v);
        check(v == 4, "R10", "count after restart", v, 4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule